// File: doc/BRIEF.md
# Occupancy-Ranked Fetch Thread Selector

This block decides, every cycle, which hardware threads of a simultaneous multithreaded front end are allowed to fetch. For each thread it holds a counter of instructions that are in flight between fetch and issue, which covers the decode, rename and issue-queue stages. The counter rises by the number of instructions fetched for that thread and falls by the number issued for it. The block ranks the threads that are not gated by these counters. The fewest in flight comes first, and an equal count is settled in favour of the lower thread index.

The front end reads up to two selected thread indices with their valid flags. It also reads a per-thread budget, which is the number of instructions that thread may fetch this cycle. The selection is combinational. It depends on the registered counters and on the gate inputs of the current cycle. Counter updates take effect at the next rising clock edge. An external policy asserts a gate bit to take a thread out of the ranking entirely.

Top module: `icount_fetch_sel`

## Requirements
- R1: Slot 0 names the eligible thread with the smallest in-flight count, and slot 1 names the smallest of the rest. A thread is eligible when its gate bit is 0.
- R2: When counts are equal, the thread with the lower index is ranked first.
- R3: At each rising edge a thread's counter changes by its fetched count minus its issued count in that cycle. Both are applied together as a single net change.
- R4: A thread whose gate bit is 1 is never selected, whatever its count.
- R5: At most two threads are selected per cycle, and two valid slots never name the same thread.
- R6: A selected thread has a budget of 8. Every other thread has a budget of 0. The budgets sum to no more than the fetch width of 16.
- R7: When fewer than two threads are eligible, the unused slots have valid 0 and thread index 0. Slot 1 is valid only if slot 0 is valid.
- R8: While rst_ni is low, all counters are cleared to 0.
- R9: A counter clamps at 0 when more instructions issue than are held. It clamps at its maximum value, 255, instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fetch_cnt_i | input | 32 | Instructions fetched this cycle, 4 bits per thread; thread t uses bits [4t+3:4t] |
| issue_cnt_i | input | 32 | Instructions issued this cycle, 4 bits per thread, same layout |
| gate_i | input | 8 | Bit t removes thread t from selection |
| sel_tid_o | output | 6 | Selected thread index per slot, 3 bits each; slot 0 in [2:0] |
| sel_vld_o | output | 2 | Valid flag per slot; slot 0 in bit 0 |
| budget_o | output | 32 | Fetch budget per thread, 4 bits each, same layout as fetch_cnt_i |

## Verification
Two things can land on the same thread in the same cycle: a fetch increment and an issue decrement. One directed phase drives both onto one thread over many cycles with different net signs. Random phases also overlap them on all threads. A behavioural model applies the net change and clamps at 0 and 255, and the bench compares every slot, flag and budget against it each cycle. A wrong update order or a dropped term shows up as a wrong ranking or a wrong budget.

// File: rtl/icount_pkg.sv
package icount_pkg;
  localparam int unsigned THREADS_DEF   = 8;
  localparam int unsigned PICKS_DEF     = 2;
  localparam int unsigned PER_THR_DEF   = 8;
  localparam int unsigned FETCH_W_DEF   = 16;
  localparam int unsigned ISSUE_MAX_DEF = 11;
  localparam int unsigned CNT_W_DEF     = 8;
endpackage

// File: rtl/icount_ctr.sv
module icount_ctr #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned FW    = 4,
  parameter int unsigned IW    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [FW-1:0]    inc_i,
  input  logic [IW-1:0]    dec_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int unsigned SW = CNT_W + 2;
  localparam logic [SW-1:0] MAXV = SW'((1 << CNT_W) - 1);

  logic [SW-1:0]    up, diff;
  logic [CNT_W-1:0] nxt;

  always_comb begin
    up   = SW'(cnt_o) + SW'(inc_i);
    diff = up - SW'(dec_i);
    if (up < SW'(dec_i))  nxt = '0;
    else if (diff > MAXV) nxt = MAXV[CNT_W-1:0];
    else                  nxt = diff[CNT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= nxt;

  // R3
  step_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    SW'(cnt_o) <= SW'($past(cnt_o)) + SW'($past(inc_i)));
  // R3
  step_dn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    SW'(cnt_o) + SW'($past(dec_i)) >= SW'($past(cnt_o)));
  // R9
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cnt_o) == MAXV[CNT_W-1:0] && $past(inc_i) >= FW'(1) && $past(dec_i) == '0)
      |-> cnt_o == MAXV[CNT_W-1:0]);
endmodule

// File: rtl/icount_rank.sv
module icount_rank #(
  parameter int unsigned N     = 8,
  parameter int unsigned NP    = 2,
  parameter int unsigned CNT_W = 8,
  parameter int unsigned TID_W = 3
) (
  input  logic [CNT_W-1:0] cnt_i [N],
  input  logic [N-1:0]     elig_i,
  output logic [TID_W-1:0] tid_o [NP],
  output logic [NP-1:0]    vld_o
);
  logic [N-1:0]     avail;
  logic             found;
  logic [TID_W-1:0] best_t;
  logic [CNT_W-1:0] best_c;

  always_comb begin
    avail = elig_i;
    for (int k = 0; k < NP; k++) begin
      found  = 1'b0;
      best_t = '0;
      best_c = '0;
      for (int t = 0; t < N; t++) begin
        // strict compare keeps the lower index on a tie
        if (avail[t] && (!found || cnt_i[t] < best_c)) begin
          found  = 1'b1;
          best_t = TID_W'(t);
          best_c = cnt_i[t];
        end
      end
      tid_o[k] = best_t;
      vld_o[k] = found;
      if (found) avail[best_t] = 1'b0;
    end
  end
endmodule

// File: rtl/icount_fetch_sel.sv
module icount_fetch_sel
  import icount_pkg::*;
#(
  parameter int unsigned N_THREADS = THREADS_DEF,
  parameter int unsigned N_PICK    = PICKS_DEF,
  parameter int unsigned PER_THR   = PER_THR_DEF,
  parameter int unsigned FETCH_W   = FETCH_W_DEF,
  parameter int unsigned ISSUE_MAX = ISSUE_MAX_DEF,
  parameter int unsigned CNT_W     = CNT_W_DEF,
  localparam int unsigned TID_W    = $clog2(N_THREADS),
  localparam int unsigned FW       = $clog2(PER_THR + 1),
  localparam int unsigned IW       = $clog2(ISSUE_MAX + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_THREADS*FW-1:0]   fetch_cnt_i,
  input  logic [N_THREADS*IW-1:0]   issue_cnt_i,
  input  logic [N_THREADS-1:0]      gate_i,
  output logic [N_PICK*TID_W-1:0]   sel_tid_o,
  output logic [N_PICK-1:0]         sel_vld_o,
  output logic [N_THREADS*FW-1:0]   budget_o
);
  localparam int unsigned SUM_W = $clog2(N_THREADS * PER_THR + 1);

  logic [CNT_W-1:0] cnt [N_THREADS];
  logic [TID_W-1:0] tid [N_PICK];
  logic [N_THREADS-1:0] picked;

  for (genvar t = 0; t < N_THREADS; t++) begin : g_thr
    icount_ctr #(.CNT_W(CNT_W), .FW(FW), .IW(IW)) u_ctr (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .inc_i (fetch_cnt_i[t*FW +: FW]),
      .dec_i (issue_cnt_i[t*IW +: IW]),
      .cnt_o (cnt[t])
    );
  end

  icount_rank #(.N(N_THREADS), .NP(N_PICK), .CNT_W(CNT_W), .TID_W(TID_W)) u_rank (
    .cnt_i (cnt),
    .elig_i(~gate_i),
    .tid_o (tid),
    .vld_o (sel_vld_o)
  );

  always_comb begin
    picked = '0;
    for (int k = 0; k < N_PICK; k++) begin
      sel_tid_o[k*TID_W +: TID_W] = tid[k];
      if (sel_vld_o[k]) picked[tid[k]] = 1'b1;
    end
    for (int t = 0; t < N_THREADS; t++)
      budget_o[t*FW +: FW] = picked[t] ? FW'(PER_THR) : '0;
  end

  logic [SUM_W-1:0] bsum;
  always_comb begin
    bsum = '0;
    for (int t = 0; t < N_THREADS; t++) bsum = bsum + SUM_W'(budget_o[t*FW +: FW]);
  end

  // R6
  budget_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bsum <= SUM_W'(FETCH_W));

  for (genvar k = 0; k < N_PICK; k++) begin : g_slot_chk
    // R4
    gated_pick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sel_vld_o[k] |-> !gate_i[sel_tid_o[k*TID_W +: TID_W]]);
    if (k > 0) begin : g_ord
      // R7
      slot_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel_vld_o[k] |-> sel_vld_o[k-1]);
      // R5
      distinct_pick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel_vld_o[k] |-> sel_tid_o[k*TID_W +: TID_W] != sel_tid_o[(k-1)*TID_W +: TID_W]);
    end
  end

  for (genvar t = 0; t < N_THREADS; t++) begin : g_min_chk
    // R1
    min_pick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_vld_o[0] && !gate_i[t]) |-> cnt[sel_tid_o[TID_W-1:0]] <= cnt[t]);
  end
endmodule

// File: tb/sim_icount_fetch_sel.sv
`timescale 1ns/1ps
module sim_icount_fetch_sel;
  localparam int N = 8, NP = 2, FW = 4, IW = 4, TW = 3, MAXC = 255;

  logic clk = 0, rst_ni = 0;
  logic [N*FW-1:0] fetch_cnt_i = '0;
  logic [N*IW-1:0] issue_cnt_i = '0;
  logic [N-1:0]    gate_i = '0;
  logic [NP*TW-1:0] sel_tid_o;
  logic [NP-1:0]    sel_vld_o;
  logic [N*FW-1:0]  budget_o;

  int vec = 0, bad = 0;
  int model [N];

  always #2.5 clk = ~clk;

  icount_fetch_sel u0 (
    .clk_i(clk), .rst_ni(rst_ni), .fetch_cnt_i(fetch_cnt_i),
    .issue_cnt_i(issue_cnt_i), .gate_i(gate_i),
    .sel_tid_o(sel_tid_o), .sel_vld_o(sel_vld_o), .budget_o(budget_o));

  task automatic compare();
    int key_best, exp_t [NP], exp_v [NP], exp_b;
    bit used [N];
    for (int t = 0; t < N; t++) used[t] = 0;
    // R1 R2: order by (count, index) as a single key
    for (int k = 0; k < NP; k++) begin
      key_best = -1; exp_t[k] = 0; exp_v[k] = 0;
      for (int t = 0; t < N; t++)
        if (!gate_i[t] && !used[t] && (key_best < 0 || model[t]*N + t < key_best)) begin
          key_best = model[t]*N + t; exp_t[k] = t; exp_v[k] = 1;
        end
      if (exp_v[k]) used[exp_t[k]] = 1;
    end
    vec++;
    for (int k = 0; k < NP; k++) begin
      if (sel_vld_o[k] !== exp_v[k][0]) begin
        bad++; $display("FAIL R7 slot%0d valid got %0b exp %0d", k, sel_vld_o[k], exp_v[k]);
      end
      if (sel_tid_o[k*TW +: TW] !== exp_t[k][TW-1:0]) begin
        bad++; $display("FAIL R1 slot%0d tid got %0d exp %0d", k, sel_tid_o[k*TW +: TW], exp_t[k]);
      end
    end
    for (int t = 0; t < N; t++) begin
      exp_b = used[t] ? 8 : 0;
      if (budget_o[t*FW +: FW] !== exp_b[FW-1:0]) begin
        bad++; $display("FAIL R6 budget t%0d got %0d exp %0d", t, budget_o[t*FW +: FW], exp_b);
      end
    end
  endtask

  // drive at negedge, compare mid-low phase, model follows the next posedge
  task automatic step(input logic [N*FW-1:0] f, input logic [N*IW-1:0] i, input logic [N-1:0] g);
    int v;
    @(negedge clk);
    fetch_cnt_i = f; issue_cnt_i = i; gate_i = g;
    #1 compare();
    for (int t = 0; t < N; t++) begin
      // R3 net change, R9 clamp
      v = model[t] + int'(f[t*FW +: FW]) - int'(i[t*IW +: IW]);
      model[t] = v < 0 ? 0 : (v > MAXC ? MAXC : v);
    end
  endtask

  function automatic logic [N*FW-1:0] one_f(int t, int v);
    logic [N*FW-1:0] r = '0; r[t*FW +: FW] = FW'(v); return r;
  endfunction
  function automatic logic [N*IW-1:0] one_i(int t, int v);
    logic [N*IW-1:0] r = '0; r[t*IW +: IW] = IW'(v); return r;
  endfunction

  initial begin
    logic [N*FW-1:0] f;
    logic [N*IW-1:0] i;
    for (int t = 0; t < N; t++) model[t] = 0;
    // R8: reset state, counters zero so threads 0 and 1 lead (R2 tie)
    #1 compare();
    repeat (3) @(posedge clk);
    #1 compare();
    @(negedge clk) rst_ni = 1;
    step('0, '0, '0);
    // R4 R7: only thread 5 eligible, then none
    step('0, '0, 8'hDF);
    step('0, '0, 8'hFF);
    // R2: gated low threads, ties among upper ones
    step('0, '0, 8'h0F);
    // R3: same-thread fetch and issue in one cycle, net up/down/zero
    step(one_f(2, 8), '0, '0);
    for (int c = 0; c < 6; c++) step(one_f(2, 6), one_i(2, 4), '0);
    for (int c = 0; c < 6; c++) step(one_f(2, 3), one_i(2, 5), '0);
    step(one_f(2, 7), one_i(2, 7), '0);
    // R9: underflow clamp at zero
    step('0, one_i(6, 11), '0);
    step(one_f(6, 1), '0, 8'h00);
    // R9: overflow clamp at max
    for (int c = 0; c < 40; c++) step(one_f(4, 8), '0, '0);
    step(one_f(4, 8), one_i(4, 1), '0);
    step(one_f(4, 1), one_i(4, 2), 8'h00);
    // random traffic with gating, R1 R4 R5 R6 R3
    for (int c = 0; c < 1500; c++) begin
      for (int t = 0; t < N; t++) begin
        f[t*FW +: FW] = FW'($urandom_range(0, 8));
        i[t*IW +: IW] = IW'($urandom_range(0, 11));
      end
      step(f, i, N'($urandom) & N'($urandom));
    end
    // R5: drain all to zero, then equal counts everywhere
    for (int c = 0; c < 30; c++) step('0, {N{4'd11}}, '0);
    step('0, '0, 8'h81);
    step('0, '0, 8'h7F);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    #500000;
    bad++;
    $display("FAIL watchdog got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule